// File: doc/BRIEF.md
# Acknowledged Transaction Sequencer

This block is the control state machine that runs a complete acknowledged radio exchange with no processor help. In transmit transaction mode, software writes a go command. The sequencer then enables the crystal oscillator and waits for it to settle. It enables the synthesizer and waits for that to settle. It then tells the datapath to send the packet held in the transmit buffer. When the datapath reports the end of transmission, the sequencer turns around to receive and waits a bounded number of cycles for an acknowledgement. It then drops to a low-power state chosen by software, either sleep (everything off) or idle (oscillator left running), and raises one of two distinct interrupts: acknowledged or timed out.

In receive transaction mode, the same go command brings the radio up and parks it in receive. Each valid data packet raises a receive interrupt. The sequencer then sends an ACK frame built outside the data buffers and returns to receive for the next packet. It leaves receive transaction mode when the mode select is cleared. During all ACK traffic the sequencer holds a write-protect on the packet buffers, so ACK frames never alter their contents.

All settle and timeout windows are counted in clock cycles. The counts come from configuration inputs and are loaded into one shared down-counter.

Top module: `txn_sequencer`

## Requirements
- R1: After reset the block is in sleep: sleep_o=1, and osc_en_o, syn_en_o, tx_en_o, rx_en_o, ack_sel_o, buf_wp_o, busy_o, go_o and all three interrupts are 0.
- R2: A go_i pulse in sleep or idle sets go_o for exactly one cycle. The go bit then clears itself as the transaction is accepted. Starting from sleep, the oscillator phase (busy_o=1, osc_en_o=1, syn_en_o=0) lasts osc_settle_i+1 cycles.
- R3: The synthesizer phase (syn_en_o=1, tx_en_o=0, rx_en_o=0) lasts syn_settle_i+1 cycles. In transmit mode it is followed by tx_en_o=1 with ack_sel_o=0, which is held until tx_done_i.
- R4: The cycle after tx_done_i, the block turns around to receive: rx_en_o=1 and tx_en_o=0.
- R5: ack_det_i seen during the acknowledgement wait ends the transaction. irq_ack_o pulses for one cycle and irq_timeout_o stays 0.
- R6: With no acknowledgement, the wait lasts ack_timeout_i+1 cycles and then ends with a one-cycle irq_timeout_o. An ack_det_i in the last wait cycle counts as an acknowledgement.
- R7: A transaction ends in sleep (all enables off, sleep_o=1) when end_sleep_i=1. It ends in idle (osc_en_o=1, sleep_o=0, busy_o=0) when end_sleep_i=0.
- R8: A go accepted in idle skips the oscillator phase and goes straight to synthesizer settle.
- R9: go_i while busy_o=1 is ignored: go_o stays 0, and no new transaction starts once the current one ends.
- R10: In receive mode (rx_mode_i=1 when go is accepted), settle leads to rx_en_o=1. A rx_valid_i pulses irq_rx_o for one cycle and starts an ACK transmit (tx_en_o=1, ack_sel_o=1) held until tx_done_i. The block then returns to rx_en_o=1.
- R11: Clearing rx_mode_i while waiting for a packet in receive mode ends the transaction in the state chosen by end_sleep_i.
- R12: buf_wp_o is 1 during the acknowledgement wait and during ACK transmit. It is 0 while a data packet is sent or awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Go command write strobe |
| rx_mode_i | input | 1 | 1 = receive transaction mode, 0 = transmit |
| end_sleep_i | input | 1 | 1 = end in sleep, 0 = end in idle |
| osc_settle_i | input | CNT_W | Oscillator settle cycles minus one |
| syn_settle_i | input | CNT_W | Synthesizer settle cycles minus one |
| ack_timeout_i | input | CNT_W | Acknowledgement wait cycles minus one |
| tx_done_i | input | 1 | Datapath finished sending a frame |
| rx_valid_i | input | 1 | Datapath received a valid data packet |
| ack_det_i | input | 1 | Datapath received an acknowledgement |
| go_o | output | 1 | Go bit readback |
| osc_en_o | output | 1 | Oscillator enable |
| syn_en_o | output | 1 | Synthesizer enable |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| ack_sel_o | output | 1 | Transmit the generated ACK frame, not the buffer |
| buf_wp_o | output | 1 | Packet buffer write-protect |
| busy_o | output | 1 | Transaction in progress |
| sleep_o | output | 1 | Block is in sleep |
| irq_ack_o | output | 1 | Acknowledgement received pulse |
| irq_timeout_o | output | 1 | Acknowledgement timeout pulse |
| irq_rx_o | output | 1 | Packet received pulse |

## Verification
The assertions assume that the datapath strobes tx_done_i, rx_valid_i and ack_det_i as single-cycle pulses, and only while the matching phase is active. They also assume the settle and timeout counts stay stable during a transaction. The stimulus changes configuration only while the block sits in sleep or idle. It raises tx_done_i only after observing a transmit enable, and ack_det_i only while the receiver is enabled for an acknowledgement. The one go pulse issued during a busy phase tests the ignore rule. The transmit runs use a table of vectors that alternate the ending state, so both the oscillator startup and the skip from idle are exercised.

// File: rtl/txn_seq_pkg.sv
`timescale 1ns/1ps
package txn_seq_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_IDLE,
    ST_OSC,
    ST_SYN,
    ST_TX,
    ST_ACKWAIT,
    ST_RXWAIT,
    ST_ACKTX
  } seq_state_e;
endpackage

// File: rtl/txn_timer.sv
`timescale 1ns/1ps
module txn_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_cnt_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/txn_seq_fsm.sv
`timescale 1ns/1ps
module txn_seq_fsm
  import txn_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_q_i,
  output logic             accept_o,
  input  logic             rx_mode_i,
  input  logic             end_sleep_i,
  input  logic [CNT_W-1:0] osc_cfg_i,
  input  logic [CNT_W-1:0] syn_cfg_i,
  input  logic [CNT_W-1:0] to_cfg_i,
  input  logic             tx_done_i,
  input  logic             rx_valid_i,
  input  logic             ack_det_i,
  input  logic             t_zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             osc_en_o,
  output logic             syn_en_o,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic             ack_sel_o,
  output logic             buf_wp_o,
  output logic             busy_o,
  output logic             sleep_o,
  output logic             irq_ack_o,
  output logic             irq_timeout_o,
  output logic             irq_rx_o
);
  seq_state_e state_q, state_d, low_pwr;
  logic mode_q;
  logic irq_ack_q, irq_to_q, irq_rx_q;

  assign low_pwr = end_sleep_i ? ST_SLEEP : ST_IDLE;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    unique case (state_q)
      ST_SLEEP:   if (go_q_i) begin accept_o = 1'b1; state_d = ST_OSC; end
      ST_IDLE:    if (go_q_i) begin accept_o = 1'b1; state_d = ST_SYN; end
      ST_OSC:     if (t_zero_i) state_d = ST_SYN;
      ST_SYN:     if (t_zero_i) state_d = mode_q ? ST_RXWAIT : ST_TX;
      ST_TX:      if (tx_done_i) state_d = ST_ACKWAIT;
      ST_ACKWAIT: if (ack_det_i || t_zero_i) state_d = low_pwr;
      ST_RXWAIT:  if (rx_valid_i) state_d = ST_ACKTX;
                  else if (!rx_mode_i) state_d = low_pwr;
      ST_ACKTX:   if (tx_done_i) state_d = ST_RXWAIT;
      default:    state_d = ST_SLEEP;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_OSC:     load_val_o = osc_cfg_i;
      ST_SYN:     load_val_o = syn_cfg_i;
      ST_ACKWAIT: load_val_o = to_cfg_i;
      default:    load_val_o = '0;
    endcase
  end
  assign load_o = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_SLEEP;
      mode_q    <= 1'b0;
      irq_ack_q <= 1'b0;
      irq_to_q  <= 1'b0;
      irq_rx_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      if (accept_o) mode_q <= rx_mode_i;
      irq_ack_q <= (state_q == ST_ACKWAIT) && ack_det_i;
      irq_to_q  <= (state_q == ST_ACKWAIT) && !ack_det_i && t_zero_i;
      irq_rx_q  <= (state_q == ST_RXWAIT) && rx_valid_i;
    end
  end

  assign osc_en_o      = (state_q != ST_SLEEP);
  assign syn_en_o      = !(state_q inside {ST_SLEEP, ST_IDLE, ST_OSC});
  assign tx_en_o       = (state_q inside {ST_TX, ST_ACKTX});
  assign rx_en_o       = (state_q inside {ST_ACKWAIT, ST_RXWAIT});
  assign ack_sel_o     = (state_q == ST_ACKTX);
  assign buf_wp_o      = (state_q inside {ST_ACKWAIT, ST_ACKTX});
  assign busy_o        = !(state_q inside {ST_SLEEP, ST_IDLE});
  assign sleep_o       = (state_q == ST_SLEEP);
  assign irq_ack_o     = irq_ack_q;
  assign irq_timeout_o = irq_to_q;
  assign irq_rx_o      = irq_rx_q;

  p_ack_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACKWAIT && ack_det_i) |=> (irq_ack_o && !irq_timeout_o));
  p_wait_ends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACKWAIT && t_zero_i) |=> !busy_o);
  p_irq_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_o || irq_timeout_o) |-> !busy_o);
  p_irq_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_ack_o && irq_timeout_o));
  p_rx_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rx_o |=> !irq_rx_o);
  p_syn_needs_osc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_en_o |-> osc_en_o);
endmodule

// File: rtl/txn_sequencer.sv
`timescale 1ns/1ps
module txn_sequencer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             rx_mode_i,
  input  logic             end_sleep_i,
  input  logic [CNT_W-1:0] osc_settle_i,
  input  logic [CNT_W-1:0] syn_settle_i,
  input  logic [CNT_W-1:0] ack_timeout_i,
  input  logic             tx_done_i,
  input  logic             rx_valid_i,
  input  logic             ack_det_i,
  output logic             go_o,
  output logic             osc_en_o,
  output logic             syn_en_o,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic             ack_sel_o,
  output logic             buf_wp_o,
  output logic             busy_o,
  output logic             sleep_o,
  output logic             irq_ack_o,
  output logic             irq_timeout_o,
  output logic             irq_rx_o
);
  logic             go_q, accept, t_load, t_zero;
  logic [CNT_W-1:0] t_val;

  // go is only latched when no transaction runs; acceptance clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                go_q <= 1'b0;
    else if (accept)            go_q <= 1'b0;
    else if (go_i && !busy_o)   go_q <= 1'b1;
  end
  assign go_o = go_q;

  txn_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .val_i  (t_val),
    .zero_o (t_zero)
  );

  txn_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .go_q_i        (go_q),
    .accept_o      (accept),
    .rx_mode_i     (rx_mode_i),
    .end_sleep_i   (end_sleep_i),
    .osc_cfg_i     (osc_settle_i),
    .syn_cfg_i     (syn_settle_i),
    .to_cfg_i      (ack_timeout_i),
    .tx_done_i     (tx_done_i),
    .rx_valid_i    (rx_valid_i),
    .ack_det_i     (ack_det_i),
    .t_zero_i      (t_zero),
    .load_o        (t_load),
    .load_val_o    (t_val),
    .osc_en_o      (osc_en_o),
    .syn_en_o      (syn_en_o),
    .tx_en_o       (tx_en_o),
    .rx_en_o       (rx_en_o),
    .ack_sel_o     (ack_sel_o),
    .buf_wp_o      (buf_wp_o),
    .busy_o        (busy_o),
    .sleep_o       (sleep_o),
    .irq_ack_o     (irq_ack_o),
    .irq_timeout_o (irq_timeout_o),
    .irq_rx_o      (irq_rx_o)
  );

  p_go_self_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_q |=> !go_q);
  p_go_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !go_q);
  p_wp_data_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && !ack_sel_o) |-> !buf_wp_o);
endmodule

// File: tb/txn_sequencer_test.sv
`timescale 1ns/1ps
module txn_sequencer_test;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic       es;
    logic [7:0] osc;
    logic [7:0] syn;
    logic [7:0] to;
    logic [7:0] ack_at;  // 255 = no acknowledgement
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd3, 8'd2, 8'd5, 8'd2},
    '{1'b0, 8'd4, 8'd1, 8'd3, 8'd255},
    '{1'b1, 8'd2, 8'd3, 8'd4, 8'd4},
    '{1'b0, 8'd0, 8'd0, 8'd2, 8'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic go = 0, rx_mode = 0, end_sleep = 1, tx_done = 0, rx_valid = 0, ack_det = 0;
  logic [CNT_W-1:0] osc_s = '0, syn_s = '0, ack_to = '0;
  logic go_o, osc_en, syn_en, tx_en, rx_en, ack_sel, buf_wp, busy, sleep_o;
  logic irq_ack, irq_to, irq_rx;
  int n_chk = 0, n_fail = 0;
  bit prev_sleep = 1'b1;

  always #5 clk = ~clk;

  txn_sequencer #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .rx_mode_i(rx_mode),
    .end_sleep_i(end_sleep), .osc_settle_i(osc_s), .syn_settle_i(syn_s),
    .ack_timeout_i(ack_to), .tx_done_i(tx_done), .rx_valid_i(rx_valid),
    .ack_det_i(ack_det), .go_o(go_o), .osc_en_o(osc_en), .syn_en_o(syn_en),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .ack_sel_o(ack_sel), .buf_wp_o(buf_wp),
    .busy_o(busy), .sleep_o(sleep_o), .irq_ack_o(irq_ack),
    .irq_timeout_o(irq_to), .irq_rx_o(irq_rx)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic pulse_go();
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    finish_run();
  end

  initial begin
    int n;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 sleep", sleep_o, 1);
    chk("R1 enables", {osc_en, syn_en, tx_en, rx_en, ack_sel, buf_wp}, 0);
    chk("R1 busy/go/irq", {busy, go_o, irq_ack, irq_to, irq_rx}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // transmit transactions from the vector table
    for (int v = 0; v < NV; v++) begin
      int exp_osc, exp_rx;
      bit acked;
      end_sleep = VECS[v].es;
      osc_s = CNT_W'(VECS[v].osc);
      syn_s = CNT_W'(VECS[v].syn);
      ack_to = CNT_W'(VECS[v].to);
      rx_mode = 1'b0;
      acked = (VECS[v].ack_at <= VECS[v].to);
      exp_osc = prev_sleep ? int'(VECS[v].osc) + 1 : 0;   // R8 idle skips osc
      exp_rx = acked ? int'(VECS[v].ack_at) + 1 : int'(VECS[v].to) + 1;
      pulse_go();
      chk("R2 go bit set", {go_o, busy}, 2'b10);
      @(negedge clk);
      chk("R2 go self-clear", go_o, 0);
      n = 0;
      while (busy && !syn_en && n < 1000) begin n++; @(negedge clk); end
      chk(prev_sleep ? "R2 osc phase" : "R8 osc skipped", n, exp_osc);
      n = 0;
      while (syn_en && !tx_en && !rx_en && n < 1000) begin n++; @(negedge clk); end
      chk("R3 syn phase", n, int'(VECS[v].syn) + 1);
      chk("R3 tx data", {tx_en, ack_sel, buf_wp, rx_en}, 4'b1000);
      repeat (2) @(negedge clk);
      chk("R3 tx held", tx_en, 1);
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      chk("R4 turnaround", {rx_en, tx_en}, 2'b10);
      chk("R12 wp in ack wait", buf_wp, 1);
      n = 0;
      while (busy && n < 1000) begin
        ack_det = (n == int'(VECS[v].ack_at));
        n++;
        @(negedge clk);
      end
      ack_det = 1'b0;
      chk(acked ? "R5 ack wait length" : "R6 timeout length", n, exp_rx);
      chk("R5 irq_ack", irq_ack, acked ? 1 : 0);
      chk("R6 irq_timeout", irq_to, acked ? 0 : 1);
      chk("R7 end state", {sleep_o, osc_en, busy}, VECS[v].es ? 3'b100 : 3'b010);
      @(negedge clk);
      chk("R5 irq one cycle", {irq_ack, irq_to}, 0);
      prev_sleep = VECS[v].es;
    end

    // R9 go while busy is ignored (start from idle)
    end_sleep = 1'b0; osc_s = 16'd1; syn_s = 16'd6; ack_to = 16'd1;
    pulse_go();
    @(negedge clk);
    @(negedge clk);
    chk("R9 busy", busy, 1);
    pulse_go();
    chk("R9 go stays clear", go_o, 0);
    n = 0;
    while (!tx_en && n < 1000) begin n++; @(negedge clk); end
    tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    repeat (6) @(negedge clk);
    chk("R9 no restart", {busy, syn_en, go_o}, 0);

    // R10/R11 receive transaction mode
    rx_mode = 1'b1; end_sleep = 1'b1; syn_s = 16'd1;
    pulse_go();
    n = 0;
    while (!rx_en && n < 1000) begin n++; @(negedge clk); end
    chk("R10 rx wait", {rx_en, tx_en, buf_wp}, 3'b100);
    repeat (2) @(negedge clk);
    rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
    chk("R10 irq_rx", irq_rx, 1);
    chk("R10 ack tx", {tx_en, ack_sel, rx_en}, 3'b110);
    chk("R12 wp in ack tx", buf_wp, 1);
    @(negedge clk);
    chk("R10 irq_rx one cycle", irq_rx, 0);
    chk("R10 ack tx held", {tx_en, ack_sel}, 2'b11);
    tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    chk("R10 back to rx", {rx_en, tx_en, ack_sel, buf_wp, busy}, 5'b10001);
    repeat (3) @(negedge clk);
    chk("R10 stays rx", rx_en, 1);
    rx_mode = 1'b0;
    @(negedge clk);
    chk("R11 exit to sleep", {busy, sleep_o, osc_en}, 3'b010);

    finish_run();
  end
endmodule